// File: doc/BRIEF.md
# Power Rail Sequencing Controller

This block drives three power-good style flags that switch supply rails on in a fixed order and off in the opposite order. A rising enable starts the power-up run: each flag goes high in turn, index 0 first, once its own step timer has run out. A falling enable starts the power-down run, which clears index 2 first and index 0 last. All step delays are counted in ticks of one master tick generator, so the ratios between the delays stay fixed. The first step of each direction carries an extra refresh allowance on top of its programmed delay.

A change of enable in the middle of a run never leaves the rails half on. If the first step of a run is still counting, the run is abandoned at once and the flags return to the stable state they had before it. In any later step the edge restarts the step now running, and the run is completed. A long settling pause follows before the opposite run begins. The flags are registered and active-high. A high flag stands for an open-drain output that is released, and a low flag stands for one that is pulled down.

Top module: `rail_sequencer`

## Requirements
- R1: While reset is high and on the first cycle after it, all three flags are low and the controller is idle in the all-off state.
- R2: After enable rises from the all-off state, flag bit 0 goes high T_UP1+T_REFRESH ticks later. Bit 1 goes high T_UP2 ticks after that, and bit 2 goes high T_UP3 ticks after bit 1.
- R3: After enable falls from the all-on state, flag bit 2 goes low T_DN1+T_REFRESH ticks later. Bit 1 goes low T_DN2 ticks after that, and bit 0 goes low T_DN3 ticks after bit 1.
- R4: The flags are always one of 000, 001, 011 or 111. At most one flag changes in any clock cycle. Flags rise only during power-up and fall only during power-down.
- R5: A falling enable seen while the first power-up step is counting returns the controller to all-off with no flag raised. A rising enable seen while the first power-down step is counting returns it to all-on with no flag lowered.
- R6: A falling enable seen during the second or third power-up step restarts that step's timer from its full delay, and power-up still completes.
- R7: When power-up completes with enable low, all flags stay high for T_SETTLE ticks. Power-down then runs as in R3.
- R8: A rising enable seen during the second or third power-down step restarts that step's timer, and power-down completes. If enable is still high, power-up starts T_SETTLE ticks after the last flag falls.
- R9: Enable passes through a two-flop synchronizer, and its edges are taken from the synchronized level. One tick lasts TICK_DIV clock cycles of a free-running prescaler, and each step's count starts on the cycle the step begins.
- R10: If enable has returned to its original level when the settling pause expires, the controller settles in the matching stable state (all-on after a pending power-down, all-off after a pending power-up) without running the reverse sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous active-high reset |
| en_i | input | 1 | Asynchronous sequence enable; high requests power-up, low requests power-down |
| rail_ok_o | output | 3 | Registered power-good flags; bit 0 is first on and last off |

## Verification
On every cycle, assertions check that the flags stay in thermometer form and that at most one of them toggles per cycle. They also check that flags rise only in power-up and fall only in power-down, and that the settling pauses keep the flags fully on or fully off. Assertions also check the prescaler spacing and that the step counter never counts upward. Several behaviours can be shown only by the bench scenarios compared against the cycle model: the exact tick count of each step, the restart of a timer after a mid-run edge, the aborts in the first step, and the choice made when a settling pause expires.

// File: rtl/rs_pkg.sv
package rs_pkg;
  typedef enum logic [2:0] {
    S_OFF    = 3'd0,
    S_UP     = 3'd1,
    S_ON     = 3'd2,
    S_DN     = 3'd3,
    S_SET_DN = 3'd4,
    S_SET_UP = 3'd5
  } seq_state_e;
endpackage

// File: rtl/rs_en_sync.sv
module rs_en_sync (
  input  logic clk,
  input  logic rst,
  input  logic async_i,
  output logic level_o,
  output logic rise_o,
  output logic fall_o
);
  logic meta_q, sync_q, prev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
      prev_q <= 1'b0;
    end else begin
      meta_q <= async_i;
      sync_q <= meta_q;
      prev_q <= sync_q;
    end
  end

  assign level_o = sync_q;
  assign rise_o  = sync_q & ~prev_q;
  assign fall_o  = ~sync_q & prev_q;
endmodule

// File: rtl/rs_tick_gen.sv
module rs_tick_gen #(
  parameter int TICK_DIV = 5000
) (
  input  logic clk,
  input  logic rst,
  output logic tick_o
);
  localparam int PW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam logic [PW-1:0] LAST = PW'(TICK_DIV - 1);

  logic [PW-1:0] pre_q;

  always_ff @(posedge clk) begin
    if (rst)          pre_q <= '0;
    else if (tick_o)  pre_q <= '0;
    else              pre_q <= pre_q + 1'b1;
  end

  assign tick_o = (pre_q == LAST);

  generate
    if (TICK_DIV > 1) begin : g_spacing
      // R9: ticks never arrive on two consecutive cycles
      p_tick_spacing_r9: assert property (@(posedge clk) disable iff (rst)
        tick_o |=> !tick_o);
    end
  endgenerate
endmodule

// File: rtl/rs_step_timer.sv
module rs_step_timer #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick_i,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic             done_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)                         cnt_q <= '0;
    else if (load_i)                 cnt_q <= load_val_i;
    else if (tick_i && cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  assign done_o = tick_i && (cnt_q == CNT_W'(1));

  // R9: without a load the count only holds or moves down
  p_cnt_down_only_r9: assert property (@(posedge clk) disable iff (rst)
    !load_i |=> (cnt_q <= $past(cnt_q)));
endmodule

// File: rtl/rail_sequencer.sv
module rail_sequencer #(
  parameter int TICK_DIV  = 5000,
  parameter int T_UP1     = 100,
  parameter int T_UP2     = 100,
  parameter int T_UP3     = 100,
  parameter int T_DN1     = 100,
  parameter int T_DN2     = 100,
  parameter int T_DN3     = 100,
  parameter int T_REFRESH = 4,
  parameter int T_SETTLE  = 1200,
  parameter int CNT_W     = 16
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       en_i,
  output logic [2:0] rail_ok_o
);
  import rs_pkg::*;

  localparam logic [1:0] LAST_STEP = 2'd2;
  localparam logic [CNT_W-1:0] SETTLE_D = CNT_W'(T_SETTLE);

  logic en_s, en_rise, en_fall, tick, done;
  logic ld;
  logic [CNT_W-1:0] ld_val;

  seq_state_e st_q, st_n;
  logic [1:0] step_q, step_n;
  logic [2:0] flags_q, flags_n;

  function automatic logic [CNT_W-1:0] up_delay(input logic [1:0] s);
    case (s)
      2'd0:    up_delay = CNT_W'(T_UP1 + T_REFRESH);
      2'd1:    up_delay = CNT_W'(T_UP2);
      default: up_delay = CNT_W'(T_UP3);
    endcase
  endfunction

  function automatic logic [CNT_W-1:0] dn_delay(input logic [1:0] s);
    case (s)
      2'd0:    dn_delay = CNT_W'(T_DN1 + T_REFRESH);
      2'd1:    dn_delay = CNT_W'(T_DN2);
      default: dn_delay = CNT_W'(T_DN3);
    endcase
  endfunction

  rs_en_sync u_sync (
    .clk     (clk),
    .rst     (rst),
    .async_i (en_i),
    .level_o (en_s),
    .rise_o  (en_rise),
    .fall_o  (en_fall)
  );

  rs_tick_gen #(.TICK_DIV(TICK_DIV)) u_tick (
    .clk    (clk),
    .rst    (rst),
    .tick_o (tick)
  );

  rs_step_timer #(.CNT_W(CNT_W)) u_timer (
    .clk        (clk),
    .rst        (rst),
    .tick_i     (tick),
    .load_i     (ld),
    .load_val_i (ld_val),
    .done_o     (done)
  );

  always_comb begin
    st_n    = st_q;
    step_n  = step_q;
    flags_n = flags_q;
    ld      = 1'b0;
    ld_val  = SETTLE_D;
    case (st_q)
      S_OFF: begin
        if (en_rise) begin
          st_n = S_UP; step_n = 2'd0; ld = 1'b1; ld_val = up_delay(2'd0);
        end
      end
      S_UP: begin
        if (en_fall && step_q == 2'd0) begin
          st_n = S_OFF; step_n = 2'd0;
        end else if (en_fall) begin
          ld = 1'b1; ld_val = up_delay(step_q);
        end else if (done) begin
          flags_n[step_q] = 1'b1;
          if (step_q != LAST_STEP) begin
            step_n = step_q + 2'd1; ld = 1'b1; ld_val = up_delay(step_q + 2'd1);
          end else if (!en_s) begin
            st_n = S_SET_DN; step_n = 2'd0; ld = 1'b1; ld_val = SETTLE_D;
          end else begin
            st_n = S_ON; step_n = 2'd0;
          end
        end
      end
      S_ON: begin
        if (en_fall) begin
          st_n = S_DN; step_n = 2'd0; ld = 1'b1; ld_val = dn_delay(2'd0);
        end
      end
      S_DN: begin
        if (en_rise && step_q == 2'd0) begin
          st_n = S_ON; step_n = 2'd0;
        end else if (en_rise) begin
          ld = 1'b1; ld_val = dn_delay(step_q);
        end else if (done) begin
          flags_n[LAST_STEP - step_q] = 1'b0;
          if (step_q != LAST_STEP) begin
            step_n = step_q + 2'd1; ld = 1'b1; ld_val = dn_delay(step_q + 2'd1);
          end else if (en_s) begin
            st_n = S_SET_UP; step_n = 2'd0; ld = 1'b1; ld_val = SETTLE_D;
          end else begin
            st_n = S_OFF; step_n = 2'd0;
          end
        end
      end
      S_SET_DN: begin
        if (done) begin
          if (!en_s) begin
            st_n = S_DN; step_n = 2'd0; ld = 1'b1; ld_val = dn_delay(2'd0);
          end else begin
            st_n = S_ON;
          end
        end
      end
      S_SET_UP: begin
        if (done) begin
          if (en_s) begin
            st_n = S_UP; step_n = 2'd0; ld = 1'b1; ld_val = up_delay(2'd0);
          end else begin
            st_n = S_OFF;
          end
        end
      end
      default: begin
        st_n = S_OFF; step_n = 2'd0; flags_n = '0;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q    <= S_OFF;
      step_q  <= 2'd0;
      flags_q <= '0;
    end else begin
      st_q    <= st_n;
      step_q  <= step_n;
      flags_q <= flags_n;
    end
  end

  assign rail_ok_o = flags_q;

  // R4: thermometer form
  p_thermo_r4: assert property (@(posedge clk) disable iff (rst)
    (!flags_q[2] || flags_q[1]) && (!flags_q[1] || flags_q[0]));
  // R4: one flag change per cycle at most
  p_one_change_r4: assert property (@(posedge clk) disable iff (rst)
    $countones(flags_q ^ $past(flags_q)) <= 1);
  // R4: rises only while powering up
  p_rise_in_up_r4: assert property (@(posedge clk) disable iff (rst)
    (|(flags_q & ~$past(flags_q))) |-> ($past(st_q) == S_UP));
  // R4: falls only while powering down
  p_fall_in_dn_r4: assert property (@(posedge clk) disable iff (rst)
    (|(~flags_q & $past(flags_q))) |-> ($past(st_q) == S_DN));
  // R5: first-step abort lands in the stable state it left
  p_abort_up_r5: assert property (@(posedge clk) disable iff (rst)
    (st_q == S_UP && step_q == 2'd0 && en_fall) |=> (st_q == S_OFF && flags_q == 3'b000));
  p_abort_dn_r5: assert property (@(posedge clk) disable iff (rst)
    (st_q == S_DN && step_q == 2'd0 && en_rise) |=> (st_q == S_ON && flags_q == 3'b111));
  // R7: settle before power-down holds all rails on
  p_settle_dn_r7: assert property (@(posedge clk) disable iff (rst)
    (st_q == S_SET_DN) |-> (flags_q == 3'b111));
  // R8: settle before power-up holds all rails off
  p_settle_up_r8: assert property (@(posedge clk) disable iff (rst)
    (st_q == S_SET_UP) |-> (flags_q == 3'b000));
endmodule

// File: tb/sim_rail_sequencer.sv
`timescale 1ns/1ps
module sim_rail_sequencer;
  localparam int DIV = 4;
  localparam int U1 = 3, U2 = 4, U3 = 5, D1 = 3, D2 = 4, D3 = 2, RF = 2, ST = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic en  = 1'b0;
  logic [2:0] rail_ok;

  int n_vec = 0;
  int n_fail = 0;
  bit finished = 1'b0;
  string cur_req = "R1";

  always #10 clk = ~clk;

  rail_sequencer #(
    .TICK_DIV(DIV), .T_UP1(U1), .T_UP2(U2), .T_UP3(U3),
    .T_DN1(D1), .T_DN2(D2), .T_DN3(D3), .T_REFRESH(RF), .T_SETTLE(ST), .CNT_W(8)
  ) u0 (
    .clk(clk), .rst(rst), .en_i(en), .rail_ok_o(rail_ok)
  );

  // Behavioural reference: phase 0 off, 1 up, 2 on, 3 down, 4 settle->down, 5 settle->up
  int m_s1, m_s2, m_s3, m_pre, m_cnt, m_phase, m_step;
  int m_on;  // number of rails currently on (flags = thermometer of m_on)

  function automatic int up_d(int s);
    return (s == 0) ? U1 + RF : (s == 1) ? U2 : U3;
  endfunction
  function automatic int dn_d(int s);
    return (s == 0) ? D1 + RF : (s == 1) ? D2 : D3;
  endfunction
  function automatic logic [2:0] thermo(int n);
    return (n == 0) ? 3'b000 : (n == 1) ? 3'b001 : (n == 2) ? 3'b011 : 3'b111;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_s1 = 0; m_s2 = 0; m_s3 = 0; m_pre = 0; m_cnt = 0;
      m_phase = 0; m_step = 0; m_on = 0;
    end else begin
      bit rise, fall, tk, dn, ld;
      int ldv;
      rise = (m_s2 == 1) && (m_s3 == 0);
      fall = (m_s2 == 0) && (m_s3 == 1);
      tk   = (m_pre == DIV - 1);
      dn   = tk && (m_cnt == 1);
      ld   = 1'b0; ldv = 0;
      case (m_phase)
        0: if (rise) begin m_phase = 1; m_step = 0; ld = 1; ldv = up_d(0); end
        1: if (fall && m_step == 0) begin m_phase = 0; m_step = 0; end
           else if (fall) begin ld = 1; ldv = up_d(m_step); end
           else if (dn) begin
             m_on = m_step + 1;
             if (m_step < 2) begin m_step++; ld = 1; ldv = up_d(m_step); end
             else if (m_s2 == 0) begin m_phase = 4; m_step = 0; ld = 1; ldv = ST; end
             else begin m_phase = 2; m_step = 0; end
           end
        2: if (fall) begin m_phase = 3; m_step = 0; ld = 1; ldv = dn_d(0); end
        3: if (rise && m_step == 0) begin m_phase = 2; m_step = 0; end
           else if (rise) begin ld = 1; ldv = dn_d(m_step); end
           else if (dn) begin
             m_on = 2 - m_step;
             if (m_step < 2) begin m_step++; ld = 1; ldv = dn_d(m_step); end
             else if (m_s2 == 1) begin m_phase = 5; m_step = 0; ld = 1; ldv = ST; end
             else begin m_phase = 0; m_step = 0; end
           end
        4: if (dn) begin
             if (m_s2 == 0) begin m_phase = 3; m_step = 0; ld = 1; ldv = dn_d(0); end
             else m_phase = 2;
           end
        default: if (dn) begin
             if (m_s2 == 1) begin m_phase = 1; m_step = 0; ld = 1; ldv = up_d(0); end
             else m_phase = 0;
           end
      endcase
      m_pre = tk ? 0 : m_pre + 1;
      if (ld) m_cnt = ldv;
      else if (tk && m_cnt != 0) m_cnt = m_cnt - 1;
      m_s3 = m_s2; m_s2 = m_s1; m_s1 = en;
    end
  end

  always @(negedge clk) begin
    if (!finished) begin
      n_vec++;
      if (rail_ok !== thermo(m_on)) begin
        n_fail++;
        $display("FAIL %s: rail_ok=%b expected=%b at %0t", cur_req, rail_ok, thermo(m_on), $time);
      end
    end
  end

  task automatic wait_cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check_flags(logic [2:0] exp, string req);
    n_vec++;
    if (rail_ok !== exp) begin
      n_fail++;
      $display("FAIL %s: rail_ok=%b expected=%b", req, rail_ok, exp);
    end
  endtask

  initial begin
    wait_cyc(5);
    check_flags(3'b000, "R1");
    rst = 1'b0;
    wait_cyc(1);
    check_flags(3'b000, "R1");

    cur_req = "R2"; en = 1'b1; wait_cyc(80);
    check_flags(3'b111, "R2");
    cur_req = "R3"; en = 1'b0; wait_cyc(80);
    check_flags(3'b000, "R3");

    cur_req = "R5"; en = 1'b1; wait_cyc(10); en = 1'b0; wait_cyc(40);
    check_flags(3'b000, "R5");
    en = 1'b1; wait_cyc(80);
    check_flags(3'b111, "R9");
    en = 1'b0; wait_cyc(8); en = 1'b1; wait_cyc(40);
    check_flags(3'b111, "R5");
    en = 1'b0; wait_cyc(80);
    check_flags(3'b000, "R3");

    cur_req = "R6"; en = 1'b1; wait_cyc(30);
    cur_req = "R7"; en = 1'b0; wait_cyc(200);
    check_flags(3'b000, "R7");

    cur_req = "R9"; en = 1'b1; wait_cyc(100);
    check_flags(3'b111, "R9");
    cur_req = "R8"; en = 1'b0; wait_cyc(28); en = 1'b1; wait_cyc(250);
    check_flags(3'b111, "R8");

    cur_req = "R10"; en = 1'b0; wait_cyc(28); en = 1'b1; wait_cyc(40); en = 1'b0; wait_cyc(250);
    check_flags(3'b000, "R10");
    en = 1'b1; wait_cyc(30); en = 1'b0; wait_cyc(35); en = 1'b1; wait_cyc(250);
    check_flags(3'b111, "R10");

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_fail++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
      $finish;
    end
  end
endmodule